// File: doc/BRIEF.md
# Supply Reset Supervisor Controller

This block is the clocked core of a reset supervisor that sits on a shared, active-low reset line. Several devices may pull that line. The block keeps reset asserted while a synchronised supply-good comparator flag is false. It also asserts reset while a debounced manual reset input is held low. Once both conditions clear, it holds reset for a further period picked by a two-bit select. Only when that period has fully elapsed does it release the line.

The block also watches the line through a low-threshold sense bit. Any device can pull the line low: this block, a processor or another device. When the line has read low for a minimum hold time, a transition flag arms. On the next rising edge the block fires a timed active-pullup pulse, so the line charges quickly. While the block itself drives the line low, it disconnects the passive pullup to save current. The analog parts appear only as sense and enable bits. All times come from a clock-frequency parameter.

Top module: `rsv_supervisor_ctrl`

## Requirements
- R1: The select `tmo_sel_i` sets the hold period: 0 gives 1 ms, 1 gives 20 ms, 2 gives 140 ms and 3 gives 1120 ms. Each period is LIM = CLK_HZ*ms/1000 cycles. After `supply_ok_i` rises, `pull_low_n_o` goes high exactly LIM+2 rising edges later.
- R2: When `supply_ok_i` falls, `pull_low_n_o` goes low on the third rising edge. Any drop of `supply_ok_i` during the count restarts the full LIM+2 edge count from the moment it returns high.
- R3: A low `mr_n_i` drives `pull_low_n_o` low on the DEB_N+3rd edge. Reset stays low while the input is low. Release comes DEB_N+LIM+2 edges after the input returns high.
- R4: A low pulse on `mr_n_i` of fewer than DEB_N clock cycles leaves `pull_low_n_o` high. A pulse of exactly DEB_N cycles asserts reset.
- R5: The transition flag arms only when `line_low_i` reads 1 (line below its low threshold) for at least HOLD cycles in a row. A shorter low gives no pullup pulse.
- R6: If the flag is armed and `line_low_i` returns to 0, `active_pu_en_o` is high for exactly PULSE cycles. It starts on the third edge after the change. The flag then clears, so no further pulse follows while the line stays high.
- R7: The pulse fires on release in the same way whether the low came from a supply dip, from the manual reset or from an external device.
- R8: `passive_pu_en_o` is 0 whenever `pull_low_n_o` is 0, and 1 whenever it is 1.
- R9: `active_pu_en_o` and a low `pull_low_n_o` are never present in the same cycle. A pulse in progress stops on the same edge at which the block asserts reset.
- R10: During and straight after reset (`rst_n` low), `pull_low_n_o`, `passive_pu_en_o` and `active_pu_en_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok_i | input | 1 | Supply-good comparator flag, 1 = supply above threshold |
| mr_n_i | input | 1 | Manual reset, active low, undebounced |
| tmo_sel_i | input | 2 | Timeout select, 0..3 = 1/20/140/1120 ms |
| line_low_i | input | 1 | Line sense, 1 = shared line below its low threshold |
| pull_low_n_o | output | 1 | Pulldown enable, 0 = drive the line low |
| passive_pu_en_o | output | 1 | Passive pullup connect enable |
| active_pu_en_o | output | 1 | Active pullup enable |

## Verification
The release count is tried on every select code. The bench samples one edge before and one edge at the expected release, which separates a correct count from an off-by-one or a mis-decoded select. A single-cycle supply dip in mid-count shows whether the counter is really cleared or merely paused. Manual-reset pulses of DEB_N-1 and DEB_N cycles bracket the debounce threshold. External line pulls one cycle shorter than the hold time, and at the hold time, bracket the arming rule. A supply drop in the middle of a pullup pulse checks the abort path, and a steady high line after a pulse shows that the flag clears.

// File: rtl/rsv_pkg.sv
// Shared helpers for the reset supervisor: converts physical times into
// clock-cycle counts. Assumes hz*time fits in 64 bits.
package rsv_pkg;

    // Cycles for a time in nanoseconds, rounded up, at least one.
    function automatic longint ns_to_cycles(longint hz, longint ns);
        longint c;
        c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
        return (c < 1) ? 64'd1 : c;
    endfunction

    // Cycles for a time in milliseconds, at least one.
    function automatic longint ms_to_cycles(longint hz, longint ms);
        longint c;
        c = (hz * ms) / 64'd1000;
        return (c < 1) ? 64'd1 : c;
    endfunction

endpackage

// File: rtl/rsv_sync.sv
// Two-flop synchroniser for W independent asynchronous bits.
// Assumes each bit is a level that is stable for many cycles; no bus coherence.
module rsv_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, sync_q;

        // Two-stage capture of one bit into the clock domain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                sync_q <= RST_VAL[i];
            end else begin
                meta_q <= d_i[i];
                sync_q <= meta_q;
            end
        end

        assign q_o[i] = sync_q;
    end

endmodule

// File: rtl/rsv_debounce.sv
// Debouncer: the output takes a new level only after the input has held
// that level for N consecutive samples. Assumes a synchronised input, N >= 2.
module rsv_debounce #(
    parameter int   N       = 4,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_i,
    output logic out_o
);

    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] cnt_q;
    logic          out_q;

    // Count consecutive samples that differ from the output; flip on the Nth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            out_q <= RST_VAL;
        end else if (in_i == out_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(N - 1)) begin
            out_q <= in_i;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign out_o = out_q;

    // R4: the output only ever moves to the level the input has been showing.
    a_r4_follow_input: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q != $past(out_q)) |-> (out_q == $past(in_i)));

endmodule

// File: rtl/rsv_timeout.sv
// Reset timeout counter. Holds reset while supply is bad or manual reset is
// low, then counts the selected period before releasing. Assumes
// synchronised and debounced inputs.
module rsv_timeout #(
    parameter longint CLK_HZ = 100_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ok_i,
    input  logic       mr_n_i,
    input  logic [1:0] sel_i,
    output logic       hold_o,
    output logic       rel_o
);

    localparam longint L0 = rsv_pkg::ms_to_cycles(CLK_HZ, 1);
    localparam longint L1 = rsv_pkg::ms_to_cycles(CLK_HZ, 20);
    localparam longint L2 = rsv_pkg::ms_to_cycles(CLK_HZ, 140);
    localparam longint L3 = rsv_pkg::ms_to_cycles(CLK_HZ, 1120);
    localparam int     CW = $clog2(L3 + 1);

    logic [CW-1:0] lim_c;
    logic [CW-1:0] cnt_q;
    logic          rel_q;

    // Decode the select code into a period length in cycles.
    always_comb begin
        case (sel_i)
            2'd0:    lim_c = CW'(L0);
            2'd1:    lim_c = CW'(L1);
            2'd2:    lim_c = CW'(L2);
            default: lim_c = CW'(L3);
        endcase
    end

    assign hold_o = !ok_i || !mr_n_i;

    // Clear on any hold condition, otherwise count up to the limit and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rel_q <= 1'b0;
        end else if (hold_o) begin
            cnt_q <= '0;
            rel_q <= 1'b0;
        end else if (cnt_q >= lim_c - 1'b1) begin
            rel_q <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign rel_o = rel_q;

    // R2: a hold condition leaves reset asserted and the count at zero.
    a_r2_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |=> (!rel_q && cnt_q == '0));

    // R1: release happens only once the count has reached the limit.
    a_r1_release_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rel_q) |-> ($past(cnt_q) + 1'b1 >= $past(lim_c)));

endmodule

// File: rtl/rsv_edge_boost.sv
// Edge-tracking one-shot. Arms when the line has read low for HOLD_CYC
// cycles, then on the line going high drives the active pullup for
// PULSE_CYC cycles and clears the flag. block_i forces the pulse off and
// stops a new one starting. Assumes a synchronised line sense.
module rsv_edge_boost #(
    parameter int HOLD_CYC  = 2,
    parameter int PULSE_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic low_i,
    input  logic block_i,
    output logic pulse_o
);

    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam int PW = $clog2(PULSE_CYC + 1);

    logic [HW-1:0] low_cnt_q;
    logic [PW-1:0] pcnt_q;
    logic          arm_q;
    logic          pulse_q;

    // Pulse sequencing first, then arming so a held low re-arms the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
            pcnt_q    <= '0;
            arm_q     <= 1'b0;
            pulse_q   <= 1'b0;
        end else begin
            if (block_i) begin
                pulse_q <= 1'b0;
                pcnt_q  <= '0;
            end else if (pulse_q) begin
                if (pcnt_q == PW'(PULSE_CYC - 1)) begin
                    pulse_q <= 1'b0;
                    arm_q   <= 1'b0;
                end else begin
                    pcnt_q <= pcnt_q + 1'b1;
                end
            end else if (arm_q && !low_i) begin
                pulse_q <= 1'b1;
                pcnt_q  <= '0;
            end

            if (low_i) begin
                if (low_cnt_q == HW'(HOLD_CYC - 1)) begin
                    arm_q <= 1'b1;
                end else begin
                    low_cnt_q <= low_cnt_q + 1'b1;
                end
            end else begin
                low_cnt_q <= '0;
            end
        end
    end

    assign pulse_o = pulse_q;

    // R6: a pulse starts only from an armed flag with the line seen high.
    a_r6_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_q) |-> ($past(arm_q) && !$past(low_i)));

    // R6: an unblocked pulse keeps going until its length is reached.
    a_r6_pulse_length: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_q && pcnt_q < PW'(PULSE_CYC - 1) && !block_i) |=> pulse_q);

endmodule

// File: rtl/rsv_supervisor_ctrl.sv
// Reset supervisor controller for a shared active-low reset line.
// Synchronises the three sense inputs, debounces manual reset, runs the
// selectable timeout and the rising-edge active-pullup one-shot.
// Assumes analog parts are external and seen only as sense/enable bits.
module rsv_supervisor_ctrl #(
    parameter longint CLK_HZ   = 100_000_000,
    parameter int     DEB_N    = 4,
    parameter longint HOLD_NS  = 20,
    parameter longint PULSE_NS = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok_i,
    input  logic       mr_n_i,
    input  logic [1:0] tmo_sel_i,
    input  logic       line_low_i,
    output logic       pull_low_n_o,
    output logic       passive_pu_en_o,
    output logic       active_pu_en_o
);

    localparam int HOLD_CYC  = int'(rsv_pkg::ns_to_cycles(CLK_HZ, HOLD_NS));
    localparam int PULSE_CYC = int'(rsv_pkg::ns_to_cycles(CLK_HZ, PULSE_NS));

    logic [2:0] sync_q;
    logic       mr_db;
    logic       hold;
    logic       rel;
    logic       pulse;

    rsv_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({line_low_i, mr_n_i, supply_ok_i}),
        .q_o   (sync_q)
    );

    rsv_debounce #(.N(DEB_N), .RST_VAL(1'b1)) u_mr_db (
        .clk   (clk),
        .rst_n (rst_n),
        .in_i  (sync_q[1]),
        .out_o (mr_db)
    );

    rsv_timeout #(.CLK_HZ(CLK_HZ)) u_tmo (
        .clk    (clk),
        .rst_n  (rst_n),
        .ok_i   (sync_q[0]),
        .mr_n_i (mr_db),
        .sel_i  (tmo_sel_i),
        .hold_o (hold),
        .rel_o  (rel)
    );

    rsv_edge_boost #(.HOLD_CYC(HOLD_CYC), .PULSE_CYC(PULSE_CYC)) u_boost (
        .clk     (clk),
        .rst_n   (rst_n),
        .low_i   (sync_q[2]),
        .block_i (hold || !rel),
        .pulse_o (pulse)
    );

    assign pull_low_n_o    = rel;
    assign passive_pu_en_o = rel;
    assign active_pu_en_o  = pulse;

    // R9: pullup pulse and own pulldown never overlap.
    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(active_pu_en_o && !pull_low_n_o));

endmodule

// File: tb/test_rsv_supervisor_ctrl.sv
module test_rsv_supervisor_ctrl;

    localparam longint CLK_HZ   = 5000;
    localparam int     DEB_N    = 4;
    localparam longint HOLD_NS  = 600_000;    // 3 cycles
    localparam longint PULSE_NS = 1_000_000;  // 5 cycles
    localparam int     HOLD     = 3;
    localparam int     PULSE    = 5;
    localparam int     LIM [4]  = '{5, 100, 700, 5600};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_ok = 1'b0;
    logic       mr_n = 1'b1;
    logic [1:0] tmo_sel = 2'd0;
    logic       ext_low = 1'b0;
    logic       line_low;
    logic       pull_low_n, passive_pu_en, active_pu_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    bit overlap_seen = 1'b0;

    always #5 clk = ~clk;

    assign line_low = !pull_low_n || ext_low;

    rsv_supervisor_ctrl #(
        .CLK_HZ(CLK_HZ), .DEB_N(DEB_N), .HOLD_NS(HOLD_NS), .PULSE_NS(PULSE_NS)
    ) i_rsv_supervisor_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .supply_ok_i     (supply_ok),
        .mr_n_i          (mr_n),
        .tmo_sel_i       (tmo_sel),
        .line_low_i      (line_low),
        .pull_low_n_o    (pull_low_n),
        .passive_pu_en_o (passive_pu_en),
        .active_pu_en_o  (active_pu_en)
    );

    always @(negedge clk) if (rst_n && active_pu_en && !pull_low_n) overlap_seen = 1'b1;

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic measure_pulse(output int len);
        len = 0;
        while (active_pu_en && len < 50) begin
            len++;
            wait_edges(1);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        wait_edges(5);
        chk("R10 pull_low_n in reset", pull_low_n, 0);
        chk("R10 passive in reset", passive_pu_en, 0);
        chk("R10 active in reset", active_pu_en, 0);
        rst_n = 1'b1;
        wait_edges(10);
        chk("R2 held low while supply bad", pull_low_n, 0);
        chk("R10 active after reset", active_pu_en, 0);
    endtask

    task automatic t_power_up();
        int len;
        supply_ok = 1'b1;
        wait_edges(LIM[0] + 1);
        chk("R1 sel0 not yet released", pull_low_n, 0);
        wait_edges(1);
        chk("R1 sel0 released", pull_low_n, 1);
        chk("R8 passive on when released", passive_pu_en, 1);
        wait_edges(2);
        chk("R7 no pulse before third edge", active_pu_en, 0);
        wait_edges(1);
        chk("R7 pulse after power-up release", active_pu_en, 1);
        measure_pulse(len);
        chk("R6 pulse length", len, PULSE);
        wait_edges(10);
        chk("R6 flag cleared, no repeat", active_pu_en, 0);
    endtask

    task automatic t_supply(input int s);
        supply_ok = 1'b0;
        tmo_sel = 2'(s);
        wait_edges(2);
        chk("R2 not yet asserted", pull_low_n, 1);
        wait_edges(1);
        chk("R2 asserted on third edge", pull_low_n, 0);
        chk("R8 passive off while driving low", passive_pu_en, 0);
        wait_edges(10);
        supply_ok = 1'b1;
        if (s == 1) begin
            wait_edges(50);
            supply_ok = 1'b0;
            wait_edges(1);
            supply_ok = 1'b1;
        end
        wait_edges(LIM[s] + 1);
        chk($sformatf("R1/R2 sel%0d not yet released", s), pull_low_n, 0);
        wait_edges(1);
        chk($sformatf("R1 sel%0d released", s), pull_low_n, 1);
        wait_edges(20);
    endtask

    task automatic t_manual();
        mr_n = 1'b0;
        wait_edges(DEB_N + 2);
        chk("R3 not yet asserted", pull_low_n, 1);
        wait_edges(1);
        chk("R3 asserted by manual reset", pull_low_n, 0);
        wait_edges(200);
        chk("R3 held while input low", pull_low_n, 0);
        mr_n = 1'b1;
        wait_edges(DEB_N + LIM[0] + 1);
        chk("R3 not yet released", pull_low_n, 0);
        wait_edges(1);
        chk("R3 released after timeout", pull_low_n, 1);
        wait_edges(3);
        chk("R7 pulse after manual reset", active_pu_en, 1);
        wait_edges(20);
    endtask

    task automatic t_glitch();
        int lows = 0;
        mr_n = 1'b0;
        wait_edges(DEB_N - 1);
        mr_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            if (!pull_low_n) lows++;
            wait_edges(1);
        end
        chk("R4 short glitch ignored", lows, 0);
        mr_n = 1'b0;
        wait_edges(DEB_N);
        mr_n = 1'b1;
        lows = 0;
        for (int i = 0; i < 25; i++) begin
            if (!pull_low_n) lows++;
            wait_edges(1);
        end
        chk("R4 pulse of DEB_N cycles asserts", (lows > 0) ? 1 : 0, 1);
        wait_edges(30);
    endtask

    task automatic t_external();
        int len;
        int highs = 0;
        ext_low = 1'b1;
        wait_edges(HOLD);
        ext_low = 1'b0;
        wait_edges(2);
        chk("R5 no pulse before third edge", active_pu_en, 0);
        wait_edges(1);
        chk("R5/R7 pulse after external pull", active_pu_en, 1);
        measure_pulse(len);
        chk("R6 external pulse length", len, PULSE);
        ext_low = 1'b1;
        wait_edges(HOLD - 1);
        ext_low = 1'b0;
        for (int i = 0; i < 15; i++) begin
            if (active_pu_en) highs++;
            wait_edges(1);
        end
        chk("R5 short pull does not arm", highs, 0);
    endtask

    task automatic t_abort();
        ext_low = 1'b1;
        wait_edges(HOLD + 1);
        ext_low = 1'b0;
        wait_edges(3);
        chk("R9 pulse running", active_pu_en, 1);
        supply_ok = 1'b0;
        wait_edges(2);
        chk("R9 pulse still on before reset", active_pu_en, 1);
        wait_edges(1);
        chk("R9 pulse stopped with reset", active_pu_en, 0);
        chk("R9 reset asserted", pull_low_n, 0);
        wait_edges(10);
        supply_ok = 1'b1;
        wait_edges(LIM[0] + 30);
        chk("R9 recovered", pull_low_n, 1);
        chk("R9 no overlap seen in run", overlap_seen ? 1 : 0, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_power_up();
        for (int s = 1; s < 4; s++) t_supply(s);
        tmo_sel = 2'd0;
        wait_edges(20);
        t_manual();
        t_glitch();
        t_external();
        t_abort();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule